// File: doc/BRIEF.md
# Dual-Slot Instruction Macro Sequencer

This block sits in the instruction issue path of a crypto coprocessor and lets a short run of instructions be captured once and issued again many times. It holds two independent sequence slots. In normal operation every accepted instruction is passed through to the issue output one cycle later. A record command tells the block to capture the next N instructions into a chosen slot. Those instructions still go through to the output while they are captured. An execute command later replays a slot's stored instructions, in order, a chosen number of times. During the replay the input stream is held off.

The controller has three named states. IDLE is pass-through. REC is capturing. EXE is replaying. The transitions are:
- IDLE to REC: a record command with a non-zero count.
- REC to IDLE: the Nth instruction has been captured.
- IDLE to EXE: an execute command with a non-zero repeat count for a slot that holds instructions.
- EXE to IDLE: the last instruction of the last repetition has been issued.

Every other command leaves the state unchanged. A status word reports the state code and the amount still outstanding. A one-cycle error pulse marks a command that was turned away.

Top module: `macro_seq`

## Requirements
- R1: An instruction carries its opcode in bits [15:11] and an immediate count in bits [3:0]. Opcode 5 records into slot 0 and opcode 7 records into slot 1, with the immediate as the number of instructions to capture. Opcode 6 replays slot 0 and opcode 8 replays slot 1, with the immediate as the number of repetitions. These four opcodes are commands; every other opcode is ordinary data.
- R2: In IDLE, an accepted ordinary instruction appears on out_instr with out_valid high exactly one cycle after acceptance. Commands are never forwarded.
- R3: A record command with count N captures exactly the next N accepted ordinary instructions into its slot. Each of them is also forwarded as in R2, and the block returns to IDLE after the Nth.
- R4: A record command with count 0 leaves the block in IDLE, and pass-through continues.
- R5: An accepted execute command causes the slot's stored instructions to be issued in capture order, once per cycle with out_valid held high, repeated the requested number of times. The first one appears two cycles after acceptance.
- R6: in_ready is low for exactly length × repetitions cycles, starting the cycle after an execute command is accepted. It is high at all other times.
- R7: An execute command for a slot that was never recorded, or with a repetition count of 0, produces no output and leaves the block in IDLE with in_ready high.
- R8: status[1:0] holds the state code: 0 for IDLE, 1 for REC, 2 for EXE. status[7:4] holds the count still outstanding: captures left in REC, or repetitions left (counting the current one) in EXE. It is 0 in IDLE, and status[3:2] is always 0.
- R9: A record or execute command accepted during REC is rejected. err goes high for exactly the next cycle, and the command is neither captured nor forwarded. The capture count does not change.
- R10: The two slots are independent. Recording one slot again replaces that slot's content and length and leaves the other slot untouched.
- R11: After reset the block is in IDLE with status 0, out_valid 0, err 0, in_ready 1, and both slots empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input instruction present |
| in_instr | input | 16 | Input instruction word |
| in_ready | output | 1 | Block can accept an input instruction |
| out_valid | output | 1 | Issued instruction present |
| out_instr | output | 16 | Issued instruction word (forwarded or replayed) |
| status | output | 8 | State code in [1:0], outstanding count in [7:4] |
| err | output | 1 | One-cycle pulse when a command is rejected |

## Verification
A wrong capture index or slot select stays hidden until that slot is replayed. It then shows up as a word that is misplaced or belongs to the other slot, so every recording is followed by replays and the outputs are compared word by word. A bad repeat or length counter shows on in_ready within the replay itself: the stall lasts the wrong number of cycles. It also shows in status[7:4] one cycle after the execute command. A decode fault on commands shows within a cycle or two, as a forwarded command word, a missing err pulse, or a status that does not move.

// File: rtl/macro_seq_pkg.sv
package macro_seq_pkg;
    localparam int unsigned OPC_W     = 5;
    localparam int unsigned NUM_SLOTS = 2;
    localparam int unsigned SLOT_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

    localparam logic [OPC_W-1:0] OPC_REC0 = 5'd5;
    localparam logic [OPC_W-1:0] OPC_EXE0 = 5'd6;
    localparam logic [OPC_W-1:0] OPC_REC1 = 5'd7;
    localparam logic [OPC_W-1:0] OPC_EXE1 = 5'd8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REC  = 2'd1,
        ST_EXE  = 2'd2
    } seq_state_t;
endpackage

// File: rtl/macro_seq_store.sv
module macro_seq_store
    import macro_seq_pkg::*;
#(
    parameter int unsigned INSTR_W = 16,
    parameter int unsigned DEPTH   = 15,
    parameter int unsigned CNT_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [SLOT_W-1:0]  wr_slot,
    input  logic [CNT_W-1:0]   wr_idx,
    input  logic [INSTR_W-1:0] wr_data,
    input  logic               len_we,
    input  logic [SLOT_W-1:0]  len_slot,
    input  logic [CNT_W-1:0]   len_val,
    input  logic [SLOT_W-1:0]  rd_slot,
    input  logic [CNT_W-1:0]   rd_idx,
    output logic [INSTR_W-1:0] rd_data,
    output logic [CNT_W-1:0]   rd_len
);
    logic [INSTR_W-1:0] slot_word [NUM_SLOTS];
    logic [CNT_W-1:0]   slot_len  [NUM_SLOTS];

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        logic [INSTR_W-1:0] mem [DEPTH];
        logic [CNT_W-1:0]   len_r;

        always_ff @(posedge clk) begin
            if (wr_en && wr_slot == SLOT_W'(s)) begin
                mem[wr_idx] <= wr_data;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                len_r <= '0;
            end else if (len_we && len_slot == SLOT_W'(s)) begin
                len_r <= len_val;
            end
        end

        assign slot_word[s] = mem[rd_idx];
        assign slot_len[s]  = len_r;
    end

    assign rd_data = slot_word[rd_slot];
    assign rd_len  = slot_len[rd_slot];

    // R3: captures never run past the slot storage
    assert_wr_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (32'(wr_idx) < DEPTH));
    // R1: a slot length never exceeds the storage depth
    assert_len_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        len_we |-> (32'(len_val) <= DEPTH));
endmodule

// File: rtl/macro_seq_fsm.sv
module macro_seq_fsm
    import macro_seq_pkg::*;
#(
    parameter int unsigned INSTR_W = 16,
    parameter int unsigned CNT_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [INSTR_W-1:0] in_instr,
    output logic               in_ready,
    output logic               wr_en,
    output logic [SLOT_W-1:0]  wr_slot,
    output logic [CNT_W-1:0]   wr_idx,
    output logic [INSTR_W-1:0] wr_data,
    output logic               len_we,
    output logic [SLOT_W-1:0]  len_slot,
    output logic [CNT_W-1:0]   len_val,
    output logic [SLOT_W-1:0]  rd_slot,
    output logic [CNT_W-1:0]   rd_idx,
    input  logic [INSTR_W-1:0] rd_data,
    input  logic [CNT_W-1:0]   rd_len,
    output logic               out_valid,
    output logic [INSTR_W-1:0] out_instr,
    output logic [CNT_W+3:0]   status,
    output logic               err
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    seq_state_t        state_q, state_d;
    logic [SLOT_W-1:0] slot_q, slot_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [CNT_W-1:0]  idx_q, idx_d;

    logic [OPC_W-1:0]  opc;
    logic [CNT_W-1:0]  imm;
    logic              is_rec, is_exe, is_cmd, accept;
    logic [SLOT_W-1:0] cmd_slot;
    logic              fwd, emit, reject;

    assign opc      = in_instr[INSTR_W-1 -: OPC_W];
    assign imm      = in_instr[CNT_W-1:0];
    assign is_rec   = (opc == OPC_REC0) || (opc == OPC_REC1);
    assign is_exe   = (opc == OPC_EXE0) || (opc == OPC_EXE1);
    assign is_cmd   = is_rec || is_exe;
    assign cmd_slot = ((opc == OPC_REC1) || (opc == OPC_EXE1)) ? SLOT_W'(1) : SLOT_W'(0);
    assign in_ready = (state_q != ST_EXE);
    assign accept   = in_valid && in_ready;

    assign wr_slot  = slot_q;
    assign wr_idx   = idx_q;
    assign wr_data  = in_instr;
    assign len_slot = cmd_slot;
    assign len_val  = imm;
    assign rd_slot  = (state_q == ST_EXE) ? slot_q : cmd_slot;
    assign rd_idx   = idx_q;

    // Next-state and control decisions
    always_comb begin
        state_d = state_q;
        slot_d  = slot_q;
        cnt_d   = cnt_q;
        idx_d   = idx_q;
        wr_en   = 1'b0;
        len_we  = 1'b0;
        fwd     = 1'b0;
        emit    = 1'b0;
        reject  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (is_rec) begin
                        if (imm != '0) begin
                            state_d = ST_REC;
                            slot_d  = cmd_slot;
                            cnt_d   = imm;
                            idx_d   = '0;
                            len_we  = 1'b1;
                        end
                    end else if (is_exe) begin
                        if (imm != '0 && rd_len != '0) begin
                            state_d = ST_EXE;
                            slot_d  = cmd_slot;
                            cnt_d   = imm;
                            idx_d   = '0;
                        end
                    end else begin
                        fwd = 1'b1;
                    end
                end
            end
            ST_REC: begin
                if (accept) begin
                    if (is_cmd) begin
                        reject = 1'b1;
                    end else begin
                        wr_en = 1'b1;
                        fwd   = 1'b1;
                        idx_d = idx_q + ONE;
                        cnt_d = cnt_q - ONE;
                        if (cnt_q == ONE) begin
                            state_d = ST_IDLE;
                        end
                    end
                end
            end
            ST_EXE: begin
                emit = 1'b1;
                if (idx_q == rd_len - ONE) begin
                    idx_d = '0;
                    cnt_d = cnt_q - ONE;
                    if (cnt_q == ONE) begin
                        state_d = ST_IDLE;
                    end
                end else begin
                    idx_d = idx_q + ONE;
                end
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            slot_q  <= '0;
            cnt_q   <= '0;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            slot_q  <= slot_d;
            cnt_q   <= cnt_d;
            idx_q   <= idx_d;
        end
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_instr <= '0;
            err       <= 1'b0;
        end else begin
            out_valid <= fwd || emit;
            if (emit) begin
                out_instr <= rd_data;
            end else if (fwd) begin
                out_instr <= in_instr;
            end
            err <= reject;
        end
    end

    assign status = {cnt_q, 2'b00, state_q};

    // R5: the replay pointer stays inside the recorded length
    assert_idx_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EXE) |-> (idx_q < rd_len));
    // R3: recording ends in IDLE once the last capture is taken
    assert_rec_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_REC && wr_en && cnt_q == ONE) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/macro_seq.sv
module macro_seq
    import macro_seq_pkg::*;
#(
    parameter int unsigned INSTR_W = 16,
    parameter int unsigned DEPTH   = 15,
    localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [INSTR_W-1:0] in_instr,
    output logic               in_ready,
    output logic               out_valid,
    output logic [INSTR_W-1:0] out_instr,
    output logic [CNT_W+3:0]   status,
    output logic               err
);
    logic               wr_en, len_we;
    logic [SLOT_W-1:0]  wr_slot, len_slot, rd_slot;
    logic [CNT_W-1:0]   wr_idx, len_val, rd_idx, rd_len;
    logic [INSTR_W-1:0] wr_data, rd_data;

    macro_seq_fsm #(.INSTR_W(INSTR_W), .CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_instr(in_instr), .in_ready(in_ready),
        .wr_en(wr_en), .wr_slot(wr_slot), .wr_idx(wr_idx), .wr_data(wr_data),
        .len_we(len_we), .len_slot(len_slot), .len_val(len_val),
        .rd_slot(rd_slot), .rd_idx(rd_idx), .rd_data(rd_data), .rd_len(rd_len),
        .out_valid(out_valid), .out_instr(out_instr), .status(status), .err(err)
    );

    macro_seq_store #(.INSTR_W(INSTR_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_slot(wr_slot), .wr_idx(wr_idx), .wr_data(wr_data),
        .len_we(len_we), .len_slot(len_slot), .len_val(len_val),
        .rd_slot(rd_slot), .rd_idx(rd_idx), .rd_data(rd_data), .rd_len(rd_len)
    );

    // R9: an error pulse always follows an accepted input
    assert_err_after_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $past(in_valid && in_ready));
    // R8: the state code 3 never appears
    assert_state_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
        status[1:0] != 2'd3);
    // R8: a busy state always has work outstanding, IDLE has none
    assert_count_live_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (status[1:0] != 2'd0) == (status[CNT_W+3:4] != '0));
    // R6: every stalled cycle issues a replayed word on the next cycle
    assert_stall_issues_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |=> out_valid);
endmodule

// File: tb/macro_seq_bench.sv
module macro_seq_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_instr = '0;
    logic        in_ready, out_valid, err;
    logic [15:0] out_instr;
    logic [7:0]  status;

    int n_chk = 0;
    int n_fail = 0;
    int err_cnt = 0;
    logic [15:0] got[$];
    logic [15:0] exp_q[$];
    logic [15:0] model[2][15];
    int mlen[2];

    macro_seq u_macro_seq (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_instr(in_instr),
        .in_ready(in_ready), .out_valid(out_valid), .out_instr(out_instr),
        .status(status), .err(err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid) got.push_back(out_instr);
            if (err) err_cnt++;
        end
    end

    task automatic report;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        report();
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] mkcmd(input int op, input int imm);
        return {5'(op), 7'b0, 4'(imm)};
    endfunction

    function automatic logic [15:0] mkdat(input int k);
        return {5'h0C, 11'(k)};
    endfunction

    task automatic send(input logic [15:0] w);
        @(negedge clk);
        in_valid = 1'b1;
        in_instr = w;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic cmp_list(input string req);
        chk(got.size() == exp_q.size(), {req, " length"}, got.size(), exp_q.size());
        for (int i = 0; i < got.size() && i < exp_q.size(); i++)
            chk(got[i] == exp_q[i], req, int'(got[i]), int'(exp_q[i]));
    endtask

    task automatic do_record(input int slot, input int n, input int base);
        got.delete();
        exp_q.delete();
        send(mkcmd(slot == 0 ? 5 : 7, n));
        @(negedge clk);
        // R8: REC code and captures left
        chk(status == {4'(n), 2'b00, 2'b01}, "R8 rec status", int'(status), int'({4'(n), 4'b0001}));
        for (int k = 0; k < n; k++) begin
            model[slot][k] = mkdat(base + k);
            exp_q.push_back(mkdat(base + k));
            send(mkdat(base + k));
        end
        mlen[slot] = n;
        @(negedge clk);
        @(negedge clk);
        cmp_list("R3 forwarded capture");
        chk(status == 8'h00, "R3 idle after capture", int'(status), 0);
    endtask

    task automatic do_exec(input int slot, input int reps);
        int stall = 0;
        int expl = mlen[slot] * reps;
        got.delete();
        exp_q.delete();
        for (int r = 0; r < reps; r++)
            for (int k = 0; k < mlen[slot]; k++) exp_q.push_back(model[slot][k]);
        send(mkcmd(slot == 0 ? 6 : 8, reps));
        for (int guard = 0; guard < 400; guard++) begin
            @(negedge clk);
            if (guard == 0 && expl > 0)
                chk(status == {4'(reps), 4'b0010}, "R8 exe status", int'(status), int'({4'(reps), 4'b0010}));
            if (in_ready) break;
            stall++;
        end
        chk(stall == expl, "R6 stall cycles", stall, expl);
        @(negedge clk);
        cmp_list(expl > 0 ? "R5 replay stream" : "R7 no replay");
        chk(status == 8'h00, "R5 idle after replay", int'(status), 0);
    endtask

    initial begin
        int lens[4] = '{1, 2, 7, 15};
        int repv[3] = '{1, 2, 15};
        mlen[0] = 0;
        mlen[1] = 0;
        repeat (3) @(negedge clk);
        // R11: reset state
        chk(status == 8'h00, "R11 status", int'(status), 0);
        chk(out_valid == 1'b0, "R11 out_valid", int'(out_valid), 0);
        chk(in_ready == 1'b1, "R11 in_ready", int'(in_ready), 1);
        chk(err == 1'b0, "R11 err", int'(err), 0);
        rst_n = 1'b1;

        // R7: replay of empty slots
        do_exec(1, 3);
        do_exec(0, 1);

        // R2: pass-through, R1 command vs data decode
        got.delete();
        exp_q.delete();
        for (int k = 0; k < 4; k++) begin
            exp_q.push_back({5'(k == 2 ? 9 : k), 11'(k * 91 + 3)});
            send({5'(k == 2 ? 9 : k), 11'(k * 91 + 3)});
        end
        @(negedge clk);
        @(negedge clk);
        cmp_list("R2 pass-through");

        // R4: zero-length record
        got.delete();
        send(mkcmd(5, 0));
        @(negedge clk);
        chk(status == 8'h00, "R4 zero record status", int'(status), 0);
        send(mkdat(1234));
        @(negedge clk);
        @(negedge clk);
        chk(got.size() == 1, "R4 pass-through after zero record", got.size(), 1);
        chk(status == 8'h00, "R4 still idle", int'(status), 0);

        // R3 R5 R6 R8: sweep of slots, lengths and repeat counts
        for (int s = 0; s < 2; s++)
            for (int li = 0; li < 4; li++) begin
                do_record(s, lens[li], s * 600 + li * 40);
                for (int ri = 0; ri < 3; ri++) do_exec(s, repv[ri]);
            end

        // R7: zero repetitions on a recorded slot
        do_exec(0, 0);

        // R10: re-record slot 0, slot 1 keeps its content
        do_record(0, 3, 1500);
        do_exec(1, 1);
        do_exec(0, 2);

        // R9: commands during REC are rejected
        got.delete();
        send(mkcmd(5, 3));
        send(mkdat(1700));
        err_cnt = 0;
        send(mkcmd(7, 2));
        @(negedge clk);
        chk(err == 1'b1, "R9 err pulse", int'(err), 1);
        chk(status == 8'h21, "R9 count unchanged", int'(status), 8'h21);
        @(negedge clk);
        chk(err == 1'b0, "R9 err one cycle", int'(err), 0);
        send(mkcmd(8, 1));
        @(negedge clk);
        chk(status == 8'h21, "R9 exec rejected", int'(status), 8'h21);
        send(mkdat(1701));
        send(mkdat(1702));
        @(negedge clk);
        @(negedge clk);
        chk(err_cnt == 2, "R9 err count", err_cnt, 2);
        exp_q.delete();
        for (int k = 0; k < 3; k++) begin
            exp_q.push_back(mkdat(1700 + k));
            model[0][k] = mkdat(1700 + k);
        end
        mlen[0] = 3;
        cmp_list("R9 commands not forwarded");
        do_exec(0, 1);
        do_exec(1, 1);

        report();
    end
endmodule